// File: doc/BRIEF.md
# Configuration Word Loader

This block is the receiving end of a programmable-logic configuration path. A host drives a program pulse. The loader then runs a timed initialization phase and raises an INIT indication. After that it takes 16-bit configuration words from the host, one at a time, and shifts each word out serially, most significant bit first, toward the configuration engine. Once a programmed number of words has been shifted out, it asserts DONE. A counter stands in for the real engine's completion logic.

The host side uses one register address for two purposes. A write to it delivers a configuration word, and a read of it returns the status word. Inside this block the write path is a valid/ready stream. A word moves only in a cycle where `word_valid` and `word_ready` are both high, and the status transmit-ready bit mirrors `word_ready`. While `word_ready` is low, the host holds its word and waits. The serial output is also a valid/ready stream. The downstream engine can stall any bit by holding `cfg_ready` low, and the loader then keeps the same bit on `cfg_bit`.

The host forms each word from two consecutive stream bytes, with the first byte as the upper half. It skips any header before the byte pair 0xFF, 0x20, so the first word it sends is 0xFF20. It expects INIT within a bounded number of polls and DONE within a bounded time after the last word, and it restarts the whole load with a new program pulse if either is late.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, `init` and `done` are low, `word_ready` and `cfg_valid` are low, and `status` reads 0x5000.
- R2: `init` stays low while `prog` is high and rises exactly INIT_CYCLES clock edges after the last edge at which `prog` was sampled high.
- R3: `status` bit 1 equals INIT, bit 2 equals transmit-ready (`word_ready`), bits 15:12 hold VERSION (default 0x5, the handshaking variant), and all other bits are zero.
- R4: A word is taken in a cycle where `word_valid` and `word_ready` are both high. From the next cycle `word_ready` is low and `cfg_valid` is high.
- R5: The 16 bits of a taken word appear on `cfg_bit` most significant bit first, one per cycle in which `cfg_valid` and `cfg_ready` are both high. While `cfg_ready` is low, `cfg_valid` stays high and `cfg_bit` does not change.
- R6: Unless it was the final word, `word_ready` is high again in the cycle after the handshake of a word's sixteenth bit.
- R7: In the cycle after the sixteenth bit of word number WORD_COUNT is shifted out, `done` is high, `init` stays high and `word_ready` is low.
- R8: While `done` is high and `prog` is low, `word_valid` has no effect: `cfg_valid` and `word_ready` stay low and `done` stays high.
- R9: A program pulse at any point, even in the middle of a word, does three things in the next cycle: it clears `done` and `init`, it drops `cfg_valid`, and it restarts the word count from zero.
- R10: Before INIT is raised, `word_ready` is low and a presented word is not taken: `cfg_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog | input | 1 | Program pulse; restarts initialization |
| word_valid | input | 1 | Host presents a configuration word |
| word_data | input | 16 | Configuration word, upper byte first in the stream |
| word_ready | output | 1 | Loader can take a word (transmit-ready) |
| status | output | 16 | Status word returned on a read of the shared address |
| cfg_valid | output | 1 | A serial bit is on `cfg_bit` |
| cfg_bit | output | 1 | Serial configuration bit, MSB first |
| cfg_ready | input | 1 | Configuration engine takes the current bit |
| init | output | 1 | Initialization complete, words accepted |
| done | output | 1 | All configured words shifted out |

## Verification
The hardest case to reach from the ports is a program pulse that lands while a word is only partly shifted out and earlier words have already been counted. If the word counter were not cleared, the next load would end one word early. To reach this case, the stimulus finishes one full word, shifts five bits of a second word and then pulses `prog`. It then re-initializes and sends exactly WORD_COUNT words, checking that `done` stays low until the final word's last bit. Stalls on `cfg_ready` follow per-word masks, so that bit hold is exercised both at word starts and in mid-word.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {
    LD_OFF  = 2'd0,
    LD_INIT = 2'd1,
    LD_LOAD = 2'd2,
    LD_DONE = 2'd3
  } ld_state_t;

  localparam int STAT_INIT_BIT  = 1;
  localparam int STAT_TXRDY_BIT = 2;
  localparam int STAT_VER_LSB   = 12;
  localparam int STAT_VER_W     = 4;
endpackage

// File: rtl/cfgld_init_timer.sv
module cfgld_init_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= START;
    end else if (restart) begin
      cnt_q <= START;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         bit_ready,
  output logic         bit_valid,
  output logic         bit_data,
  output logic         word_end
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] left_q;
  logic          fire;

  assign bit_valid = (left_q != '0);
  assign bit_data  = shreg_q[W-1];
  assign fire      = bit_valid && bit_ready;
  assign word_end  = fire && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (flush) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (load && !bit_valid) begin
      shreg_q <= load_word;
      left_q  <= CW'(W);
    end else if (fire) begin
      shreg_q <= {shreg_q[W-2:0], 1'b0};
      left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfgld_word_tally.sv
module cfgld_word_tally #(
  parameter int COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic final_step
);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt_q;

  assign final_step = step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          INIT_CYCLES = 20,
  parameter int          WORD_COUNT  = 4,
  parameter logic [3:0]  VERSION     = 4'h5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic [15:0]       status,
  output logic              cfg_valid,
  output logic              cfg_bit,
  input  logic              cfg_ready,
  output logic              init,
  output logic              done
);
  ld_state_t state_q, state_d;
  logic      timer_expired;
  logic      word_end;
  logic      last_word;
  logic      accept;

  cfgld_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (prog),
    .run     (state_q == LD_INIT),
    .expired (timer_expired)
  );

  assign word_ready = (state_q == LD_LOAD) && !cfg_valid;
  assign accept     = word_valid && word_ready;

  cfgld_serializer #(.W(WORD_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (prog),
    .load      (accept),
    .load_word (word_data),
    .bit_ready (cfg_ready),
    .bit_valid (cfg_valid),
    .bit_data  (cfg_bit),
    .word_end  (word_end)
  );

  cfgld_word_tally #(.COUNT(WORD_COUNT)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (prog),
    .step       (word_end),
    .final_step (last_word)
  );

  always_comb begin
    state_d = state_q;
    if (prog) begin
      state_d = LD_INIT;
    end else begin
      unique case (state_q)
        LD_INIT: if (timer_expired) state_d = LD_LOAD;
        LD_LOAD: if (last_word)     state_d = LD_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_OFF;
    else        state_q <= state_d;
  end

  assign init = (state_q == LD_LOAD) || (state_q == LD_DONE);
  assign done = (state_q == LD_DONE);

  always_comb begin
    status = '0;
    status[STAT_INIT_BIT]  = init;
    status[STAT_TXRDY_BIT] = word_ready;
    status[STAT_VER_LSB +: STAT_VER_W] = VERSION;
  end
endmodule

// File: rtl/cfgld_loader_chk.sv
module cfgld_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic prog,
  input logic word_valid,
  input logic word_ready,
  input logic cfg_valid,
  input logic cfg_bit,
  input logic cfg_ready,
  input logic init,
  input logic done
);
  a_r4_take_starts_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && !prog) |=> (!word_ready && cfg_valid));

  a_r5_stall_holds_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready && !prog) |=> (cfg_valid && $stable(cfg_bit)));

  a_r6_no_ready_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> !cfg_valid);

  a_r7_done_keeps_init: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (init && !word_ready));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !prog) |=> (done && !cfg_valid));

  a_r9_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (!init && !done && !cfg_valid));

  a_r10_ready_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> init);
endmodule

bind cfgld_loader cfgld_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog       (prog),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .cfg_valid  (cfg_valid),
  .cfg_bit    (cfg_bit),
  .cfg_ready  (cfg_ready),
  .init       (init),
  .done       (done)
);

// File: tb/cfgld_loader_test.sv
module cfgld_loader_test;
  localparam int INIT_N  = 20;
  localparam int WORDS   = 4;

  // each entry: {word, cfg_ready pattern indexed by cycle mod 16}
  localparam logic [31:0] VEC [WORDS] = '{
    {16'hFF20, 16'hFFFF},
    {16'hA55A, 16'hAAAA},
    {16'h8001, 16'h0F0F},
    {16'h7FFE, 16'h1111}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready;
  logic [15:0] status;
  logic        cfg_valid;
  logic        cfg_bit;
  logic        cfg_ready = 1'b0;
  logic        init;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfgld_loader #(.WORD_W(16), .INIT_CYCLES(INIT_N), .WORD_COUNT(WORDS), .VERSION(4'h5)) uut (
    .clk(clk), .rst_n(rst_n), .prog(prog), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .status(status),
    .cfg_valid(cfg_valid), .cfg_bit(cfg_bit), .cfg_ready(cfg_ready),
    .init(init), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // pulse prog for one cycle; returns at the negedge after the sampling edge
  task automatic pulse_prog();
    @(negedge clk); prog = 1'b1;
    @(posedge clk);
    @(negedge clk); prog = 1'b0;
  endtask

  // called at the negedge after pulse_prog; returns at negedge with init high
  task automatic wait_init();
    repeat (INIT_N) @(posedge clk);
    @(negedge clk);
  endtask

  // at a negedge: present word, returns at negedge after acceptance
  task automatic send_word(input logic [15:0] w);
    word_valid = 1'b1; word_data = w;
    chk(word_ready === 1'b1, "R6 ready before word", 32'(word_ready), 1);
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    chk(!word_ready && cfg_valid, "R4 busy after take", {word_ready, cfg_valid}, 2'b01);
  endtask

  // at a negedge: shift out 16 bits under a ready pattern
  task automatic recv_word(input logic [15:0] mask, output logic [15:0] got, output bit hold_ok);
    int n = 0;
    int idx = 0;
    bit stalled = 1'b0;
    logic held = 1'b0;
    hold_ok = 1'b1;
    got = '0;
    while (n < 16 && idx < 400) begin
      cfg_ready = mask[idx % 16];
      if (!cfg_valid) hold_ok = 1'b0;
      if (stalled && cfg_bit !== held) hold_ok = 1'b0;
      if (cfg_ready && cfg_valid) begin
        got = {got[14:0], cfg_bit};
        n++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        held = cfg_bit;
      end
      idx++;
      @(posedge clk);
      @(negedge clk);
    end
    cfg_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    bit hold_ok;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!init && !done && !word_ready && !cfg_valid, "R1 reset outputs",
        {init, done, word_ready, cfg_valid}, 0);
    chk(status === 16'h5000, "R1 reset status", status, 16'h5000);
    rst_n = 1'b1;

    // R10 words ignored before init
    @(negedge clk);
    word_valid = 1'b1; word_data = 16'hDEAD;
    repeat (4) @(negedge clk);
    chk(!word_ready && !cfg_valid, "R10 ignored before init", {word_ready, cfg_valid}, 0);
    word_valid = 1'b0;

    // R2 init held low while prog stays high
    prog = 1'b1;
    repeat (INIT_N + 5) @(negedge clk);
    chk(init === 1'b0, "R2 init low during prog", 32'(init), 0);
    prog = 1'b0;
    // R2 timing: last prog edge already passed; INIT_N-1 more edges -> still low
    word_valid = 1'b1; word_data = 16'hBEEF;
    repeat (INIT_N - 1) @(posedge clk);
    @(negedge clk);
    chk(init === 1'b0 && !cfg_valid, "R2 init one edge early / R10", {init, cfg_valid}, 0);
    word_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(init === 1'b1, "R2 init at INIT_CYCLES", 32'(init), 1);
    chk(status === 16'h5006, "R3 status init+ready", status, 16'h5006);

    // one full word, then abort mid-word (R9)
    send_word(16'h1234);
    chk(status === 16'h5002, "R3 status busy", status, 16'h5002);
    recv_word(16'hFFFF, got, hold_ok);
    chk(got === 16'h1234, "R5 word order", got, 16'h1234);
    send_word(16'h0F0F);
    cfg_ready = 1'b1;
    repeat (5) @(negedge clk);
    cfg_ready = 1'b0;
    pulse_prog();
    chk(!init && !done && !cfg_valid && !word_ready, "R9 mid-word program",
        {init, done, cfg_valid, word_ready}, 0);
    wait_init();

    // table of vectors: count restarts from zero (R9), MSB-first (R5), stalls
    for (int v = 0; v < WORDS; v++) begin
      send_word(VEC[v][31:16]);
      recv_word(VEC[v][15:0], got, hold_ok);
      chk(got === VEC[v][31:16], "R5 serial word", got, VEC[v][31:16]);
      chk(hold_ok, "R5 bit held in stall", 32'(hold_ok), 1);
      if (v < WORDS - 1) begin
        chk(word_ready && !done, "R6 ready again / R9 count restarted",
            {word_ready, done}, 2'b10);
      end else begin
        chk(done && init && !word_ready, "R7 done after last word",
            {done, init, word_ready}, 3'b110);
      end
    end

    // R8 writes ignored in done
    word_valid = 1'b1; word_data = 16'hFFFF;
    repeat (5) begin
      @(negedge clk);
    end
    chk(!cfg_valid && !word_ready && done, "R8 no effect in done",
        {cfg_valid, word_ready, done}, 3'b001);
    chk(status === 16'h5002, "R3 status in done", status, 16'h5002);
    word_valid = 1'b0;

    // R9 program from done
    pulse_prog();
    chk(!done && !init, "R9 program clears done", {done, init}, 0);
    chk(status === 16'h5000, "R3 status after program", status, 16'h5000);

    finish_run();
  end
endmodule